// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a master-only serial peripheral engine that works through a list of up to 32 transfers without help from the processor. Software fills three small on-block memories through a word-addressed register bus: outgoing data words, one command byte per entry, and (read back afterwards) the incoming data words. Software then sets the clock divisor, word length, clock polarity and phase, the delays around each transfer, and the first and last queue index.

Writing the start bit runs the entries from the first index up to the last index. For each entry the engine drives the chip-select pattern held in its command byte, shifts the outgoing word out most significant bit first and captures the incoming word into the receive memory at the same index. A keep bit in the command byte lets the chip selects stay asserted into the next entry. When the last entry closes, the start bit clears itself, a finished flag is raised and every chip select returns to its inactive level. Software detects completion by polling the start bit.

Top module: `qspi_master`

## Requirements
- R1: After reset, cs, mosi and sclk are 0, and all four control words (offsets 0 to 3) read 0.
- R2: Writing 1 to bit 15 of the run word (offset 1) starts the queue only when the enable bit (bit 15 of the mode word, offset 0) is already 1. The start bit reads 1 from the clock after the write until the last entry closes, then reads 0. With enable 0 the write leaves the start bit at 0 and cs at 0.
- R3: Entries run in increasing index order, from the first-index field (bits 4:0 of the queue word, offset 2) to the last-index field (bits 12:8), the index wrapping from 31 to 0. Each entry takes one load clock (cs still showing the previous value), then pre+1 clocks with the new pattern before shifting starts (pre = bits 14:8 of the run word), then the shift phase, then one capture clock, then post+1 clocks (post = bits 7:0 of the run word).
- R4: During the shift phase sclk toggles every D clocks, where D is the divisor field (bits 7:0 of the mode word) and a value of 0 acts as 1. Each entry gives 2N toggles, the first one D clocks after the shift phase begins. Outside the shift phase sclk equals the polarity bit (bit 9 of the mode word).
- R5: The word length N is the 4-bit field in bits 13:10 of the mode word, with 0 meaning 16. The outgoing word's bit N-1 is sent first, and mosi is 0 outside the shift phase.
- R6: With the phase bit (bit 8 of the mode word) at 0, mosi holds the first bit from the start of the shift phase, miso is sampled on odd-numbered sclk toggles and mosi advances on even-numbered ones. With the phase bit at 1, mosi is 0 until the first toggle, advances on odd-numbered toggles, and miso is sampled on even-numbered ones.
- R7: The N sampled bits are written to the receive memory at the entry's index, right-aligned with zeros above, in the capture clock after the last toggle. The receive memory is written only while the queue runs.
- R8: Bits CS_W-1:0 of an entry's command byte are driven on cs from the clock after the load clock until the entry closes. If bit 7 of the command byte is 0, cs is 0 during the next entry's load clock. If bit 7 is 1, the pattern is held through that load clock.
- R9: When the last entry closes, cs returns to 0 whatever its bit 7 holds. The status word (offset 3) then shows the finished flag in bit 7 and the last executed index in bits 4:0. Writing 1 to bit 7 of the status word clears the flag.
- R10: Bus address bits 6:5 select the region: 0 for the control words (offset in bits 1:0), 1 for transmit memory, 2 for receive memory and 3 for command memory, with the entry index in bits 4:0. Command memory reads return the byte in bits 7:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the register and memory bus |
| bus_addr | input | 7 | Word address: region in 6:5, index or offset below |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | CS_W | Chip-select lines, 0 is the inactive level |

## Verification
The properties assume that software leaves the mode, run and queue words alone while the start bit is 1. The block discards such writes, so the polarity, enable and end pointer the properties rely on stay fixed for a whole run. They also assume that the enable bit is written before the start bit and not in the same write. The stimulus writes the mode and queue words, then the memories, and only then the start bit, and during a run it touches the bus only to read the run word. Every command byte the stimulus uses carries a non-zero chip-select pattern, and miso is driven only in the clock just before the edge on which the block samples it.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  localparam int PTR_W   = 5;
  localparam int DEPTH   = 1 << PTR_W;
  localparam int DATA_W  = 16;
  localparam int LEN_W   = $clog2(DATA_W);
  localparam int CMD_W   = 8;
  localparam int KEEP_BIT = 7;
  localparam int ADDR_W  = PTR_W + 2;

  // region selector in the top two address bits
  localparam logic [1:0] RGN_CTRL = 2'd0;
  localparam logic [1:0] RGN_TX   = 2'd1;
  localparam logic [1:0] RGN_RX   = 2'd2;
  localparam logic [1:0] RGN_CMD  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_PRE, ST_SHIFT, ST_RXWR, ST_POST
  } qspi_state_e;

  typedef struct packed {
    logic             en;
    logic [LEN_W-1:0] bits;
    logic             cpol;
    logic             cpha;
    logic [7:0]       div;
    logic [6:0]       pre;
    logic [7:0]       post;
    logic [PTR_W-1:0] endp;
    logic [PTR_W-1:0] firstp;
  } qspi_cfg_t;

endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/qspi_regs.sv
module qspi_regs
  import qspi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       waddr,
  input  logic [15:0]      wdata,
  input  logic             ent_done,
  input  logic             q_done,
  input  logic [PTR_W-1:0] eng_idx,
  output qspi_cfg_t        cfg,
  output logic             busy,
  output logic             launch,
  output logic             fin,
  output logic [PTR_W-1:0] last_idx
);

  qspi_cfg_t        cfg_q, cfg_n;
  logic             busy_q, busy_n;
  logic             fin_q, fin_n;
  logic [PTR_W-1:0] last_q, last_n;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[14], wdata[6:5]};

  always_comb begin
    cfg_n  = cfg_q;
    busy_n = busy_q;
    fin_n  = fin_q;
    last_n = last_q;
    launch = 1'b0;
    // control words are frozen while a queue runs
    if (we && !busy_q) begin
      case (waddr)
        2'd0: begin
          cfg_n.en   = wdata[15];
          cfg_n.bits = wdata[13:10];
          cfg_n.cpol = wdata[9];
          cfg_n.cpha = wdata[8];
          cfg_n.div  = wdata[7:0];
        end
        2'd1: begin
          cfg_n.pre  = wdata[14:8];
          cfg_n.post = wdata[7:0];
          if (wdata[15] && cfg_q.en) begin
            busy_n = 1'b1;
            launch = 1'b1;
          end
        end
        2'd2: begin
          cfg_n.endp   = wdata[8 +: PTR_W];
          cfg_n.firstp = wdata[PTR_W-1:0];
        end
        default: ;
      endcase
    end
    if (we && waddr == 2'd3 && wdata[7]) fin_n = 1'b0;
    if (ent_done) last_n = eng_idx;
    if (q_done) begin
      busy_n = 1'b0;
      fin_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      last_q <= '0;
    end else begin
      cfg_q  <= cfg_n;
      busy_q <= busy_n;
      fin_q  <= fin_n;
      last_q <= last_n;
    end
  end

  assign cfg      = cfg_q;
  assign busy     = busy_q;
  assign fin      = fin_q;
  assign last_idx = last_q;

endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
  import qspi_pkg::*;
#(
  parameter int CS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qspi_cfg_t         cfg,
  input  logic              go,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              miso,
  output logic [PTR_W-1:0]  idx,
  output logic              rx_we,
  output logic [DATA_W-1:0] rx_word,
  output logic              ent_done,
  output logic              q_done,
  output logic [CS_W-1:0]   cs,
  output logic              sclk,
  output logic              mosi
);

  localparam int EDGE_W = LEN_W + 1;

  qspi_state_e       state_q, state_n;
  logic [PTR_W-1:0]  idx_q, idx_n;
  logic [7:0]        cnt_q, cnt_n;
  logic [7:0]        hc_q, hc_n;
  logic [EDGE_W-1:0] edge_q, edge_n;
  logic              lvl_q, lvl_n;
  logic [DATA_W-1:0] txs_q, txs_n;
  logic [DATA_W-1:0] rxs_q, rxs_n;
  logic              mosi_q, mosi_n;
  logic [CS_W-1:0]   cs_q, cs_n;
  logic              keep_q, keep_n;

  logic [LEN_W-1:0]  msb_pos;
  logic [EDGE_W-1:0] last_edge;
  logic [7:0]        div_m1;
  logic              sample;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg.en, cmd_byte[KEEP_BIT-1:CS_W]};

  // length field 0 wraps to the full word
  assign msb_pos   = cfg.bits - 1'b1;
  assign last_edge = {msb_pos, 1'b1};
  assign div_m1    = (cfg.div == 8'd0) ? 8'd0 : cfg.div - 8'd1;

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    cnt_n    = cnt_q;
    hc_n     = hc_q;
    edge_n   = edge_q;
    lvl_n    = lvl_q;
    txs_n    = txs_q;
    rxs_n    = rxs_q;
    mosi_n   = mosi_q;
    cs_n     = cs_q;
    keep_n   = keep_q;
    rx_we    = 1'b0;
    ent_done = 1'b0;
    q_done   = 1'b0;
    // leading toggle samples in phase 0, trailing toggle in phase 1
    sample   = (~lvl_q) ^ cfg.cpha;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          idx_n   = cfg.firstp;
          state_n = ST_LOAD;
        end
      end
      ST_LOAD: begin
        txs_n   = tx_word;
        rxs_n   = '0;
        cs_n    = cmd_byte[CS_W-1:0];
        keep_n  = cmd_byte[KEEP_BIT];
        cnt_n   = '0;
        state_n = ST_PRE;
      end
      ST_PRE: begin
        if (cnt_q == {1'b0, cfg.pre}) begin
          state_n = ST_SHIFT;
          hc_n    = '0;
          edge_n  = '0;
          lvl_n   = 1'b0;
          mosi_n  = 1'b0;
          if (!cfg.cpha) begin
            mosi_n = txs_q[msb_pos];
            txs_n  = txs_q << 1;
          end
        end else begin
          cnt_n = cnt_q + 8'd1;
        end
      end
      ST_SHIFT: begin
        if (hc_q == div_m1) begin
          hc_n   = '0;
          lvl_n  = ~lvl_q;
          edge_n = edge_q + 1'b1;
          if (sample) begin
            rxs_n = {rxs_q[DATA_W-2:0], miso};
          end else begin
            mosi_n = txs_q[msb_pos];
            txs_n  = txs_q << 1;
          end
          if (edge_q == last_edge) state_n = ST_RXWR;
        end else begin
          hc_n = hc_q + 8'd1;
        end
      end
      ST_RXWR: begin
        rx_we   = 1'b1;
        cnt_n   = '0;
        state_n = ST_POST;
      end
      ST_POST: begin
        if (cnt_q == cfg.post) begin
          ent_done = 1'b1;
          if (idx_q == cfg.endp) begin
            q_done  = 1'b1;
            cs_n    = '0;
            state_n = ST_IDLE;
          end else begin
            idx_n   = idx_q + 1'b1;
            if (!keep_q) cs_n = '0;
            state_n = ST_LOAD;
          end
        end else begin
          cnt_n = cnt_q + 8'd1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      hc_q    <= '0;
      edge_q  <= '0;
      lvl_q   <= 1'b0;
      txs_q   <= '0;
      rxs_q   <= '0;
      mosi_q  <= 1'b0;
      cs_q    <= '0;
      keep_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      hc_q    <= hc_n;
      edge_q  <= edge_n;
      lvl_q   <= lvl_n;
      txs_q   <= txs_n;
      rxs_q   <= rxs_n;
      mosi_q  <= mosi_n;
      cs_q    <= cs_n;
      keep_q  <= keep_n;
    end
  end

  assign idx     = idx_q;
  assign rx_word = rxs_q;
  assign cs      = cs_q;
  assign sclk    = cfg.cpol ^ lvl_q;
  assign mosi    = (state_q == ST_SHIFT) ? mosi_q : 1'b0;

endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int CS_W     = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   cs
);

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_LEN-1:0] sync_q;
  logic                rst_sync_n;

  generate
    for (genvar s = 0; s < SYNC_LEN; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate
  assign rst_sync_n = sync_q[SYNC_LEN-1];

  logic [1:0]        region;
  logic [PTR_W-1:0]  bus_idx;
  qspi_cfg_t         cfg;
  logic              busy, launch, fin, ent_done, q_done, rx_we;
  logic [PTR_W-1:0]  last_idx, eng_idx;
  logic [DATA_W-1:0] tx_eng, tx_bus, rx_bus, rx_word;
  logic [CMD_W-1:0]  cmd_eng, cmd_bus;
  logic              unused_hi;

  assign region    = bus_addr[ADDR_W-1 -: 2];
  assign bus_idx   = bus_addr[PTR_W-1:0];
  assign unused_hi = ^{bus_wdata[15:CMD_W], bus_addr[PTR_W-1:2], rx_eng_unused};

  qspi_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (bus_we && region == RGN_CTRL),
    .waddr    (bus_addr[1:0]),
    .wdata    (bus_wdata),
    .ent_done (ent_done),
    .q_done   (q_done),
    .eng_idx  (eng_idx),
    .cfg      (cfg),
    .busy     (busy),
    .launch   (launch),
    .fin      (fin),
    .last_idx (last_idx)
  );

  qspi_engine #(.CS_W(CS_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg      (cfg),
    .go       (launch),
    .tx_word  (tx_eng),
    .cmd_byte (cmd_eng),
    .miso     (miso),
    .idx      (eng_idx),
    .rx_we    (rx_we),
    .rx_word  (rx_word),
    .ent_done (ent_done),
    .q_done   (q_done),
    .cs       (cs),
    .sclk     (sclk),
    .mosi     (mosi)
  );

  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_ram (
    .clk     (clk),
    .we      (bus_we && region == RGN_TX),
    .waddr   (bus_idx),
    .wdata   (bus_wdata),
    .raddr_a (eng_idx),
    .rdata_a (tx_eng),
    .raddr_b (bus_idx),
    .rdata_b (tx_bus)
  );

  // the engine's capture write wins over a bus write in the same clock
  logic [DATA_W-1:0] rx_eng_unused;
  qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_ram (
    .clk     (clk),
    .we      (rx_we || (bus_we && region == RGN_RX)),
    .waddr   (rx_we ? eng_idx : bus_idx),
    .wdata   (rx_we ? rx_word : bus_wdata),
    .raddr_a (eng_idx),
    .rdata_a (rx_eng_unused),
    .raddr_b (bus_idx),
    .rdata_b (rx_bus)
  );

  qspi_ram #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_ram (
    .clk     (clk),
    .we      (bus_we && region == RGN_CMD),
    .waddr   (bus_idx),
    .wdata   (bus_wdata[CMD_W-1:0]),
    .raddr_a (eng_idx),
    .rdata_a (cmd_eng),
    .raddr_b (bus_idx),
    .rdata_b (cmd_bus)
  );

  always_comb begin
    bus_rdata = '0;
    case (region)
      RGN_CTRL: begin
        case (bus_addr[1:0])
          2'd0: bus_rdata = {cfg.en, 1'b0, cfg.bits, cfg.cpol, cfg.cpha, cfg.div};
          2'd1: bus_rdata = {busy, cfg.pre, cfg.post};
          2'd2: bus_rdata = {3'b0, cfg.endp, 3'b0, cfg.firstp};
          default: bus_rdata = {8'b0, fin, 2'b0, last_idx};
        endcase
      end
      RGN_TX:  bus_rdata = tx_bus;
      RGN_RX:  bus_rdata = rx_bus;
      default: bus_rdata = {8'b0, cmd_bus};
    endcase
  end

endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            en,
  input logic            fin,
  input logic [CS_W-1:0] cs,
  input logic            sclk,
  input logic            cpol,
  input logic            rx_we
);

  // R2: a run can only begin with the enable bit set
  assert_start_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> en);

  // R9: no chip select is active outside a run
  assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs == '0);

  // R9: the start bit only clears together with the finished flag
  assert_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> fin);

  // R7: capture writes happen only inside a run
  assert_rx_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> busy);

  // R4: serial clock rests at the polarity level when idle
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);

endmodule

bind qspi_master qspi_master_chk #(.CS_W(CS_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .busy  (busy),
  .en    (cfg.en),
  .fin   (fin),
  .cs    (cs),
  .sclk  (sclk),
  .cpol  (cfg.cpol),
  .rx_we (rx_we)
);

// File: tb/qspi_master_tb.sv
module qspi_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CS_W = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [CS_W-1:0] cs;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] txw [32];
  logic [15:0] slw [32];
  logic [7:0]  cmdw [32];
  logic [15:0] exp_rx [32];
  logic [7:0]  expq [$];   // {busy, miso, mosi, sclk, cs}
  int          runq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_master #(.CS_W(CS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs(cs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] pk(input logic [3:0] c, input logic s,
                                    input logic mo, input logic b, input logic mi);
    return {b, mi, mo, s, c};
  endfunction

  // behavioural timeline of one queue run, one word per clock
  task automatic build(input int bits, input logic cpol, input logic cpha, input int dv,
                       input int pre, input int post, input int firstp, input int endp);
    int n, d, i;
    logic [3:0] prev, pat;
    logic mo, mi;
    n = (bits == 0) ? 16 : bits;
    d = (dv == 0) ? 1 : dv;
    i = firstp;
    prev = '0;
    expq.delete();
    runq.delete();
    forever begin
      pat = cmdw[i][3:0];
      runq.push_back(i);
      expq.push_back(pk(prev, cpol, 1'b0, 1'b1, 1'b0));
      repeat (pre + 1) expq.push_back(pk(pat, cpol, 1'b0, 1'b1, 1'b0));
      for (int j = 0; j < 2*n; j++) begin
        if (cpha) mo = (j == 0) ? 1'b0 : txw[i][n-1-(j-1)/2];
        else      mo = txw[i][n-1-j/2];
        mi = slw[i][n-1-j/2];
        for (int k = 0; k < d; k++)
          expq.push_back(pk(pat, cpol ^ j[0], mo, 1'b1, mi));
      end
      repeat (post + 2) expq.push_back(pk(pat, cpol, 1'b0, 1'b1, 1'b0));
      exp_rx[i] = (n == 16) ? slw[i] : (slw[i] & 16'((1 << n) - 1));
      if (i == endp) break;
      prev = cmdw[i][7] ? pat : 4'h0;
      i = (i + 1) % 32;
    end
    repeat (2) expq.push_back(pk(4'h0, cpol, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic run_queue(input int bits, input logic cpol, input logic cpha, input int dv,
                           input int pre, input int post, input int firstp, input int endp);
    logic [7:0]  e;
    logic [15:0] rd;
    bus_write(7'h00, {1'b1, 1'b0, 4'(bits), cpol, cpha, 8'(dv)});
    bus_write(7'h02, {3'b0, 5'(endp), 3'b0, 5'(firstp)});
    build(bits, cpol, cpha, dv, pre, post, firstp, endp);
    bus_write(7'h01, {1'b1, 7'(pre), 8'(post)});
    bus_addr = 7'h01;
    while (expq.size() > 0) begin
      e = expq.pop_front();
      miso = e[6];
      #1;
      check("R3 R8 cs", 32'(cs), 32'(e[3:0]));
      check("R4 sclk", 32'(sclk), 32'(e[4]));
      check("R5 R6 mosi", 32'(mosi), 32'(e[5]));
      check("R2 start bit", 32'(bus_rdata[15]), 32'(e[7]));
      @(negedge clk);
    end
    miso = 1'b0;
    foreach (runq[q]) begin
      bus_read(7'h40 + 7'(runq[q]), rd);
      check("R7 rx word", 32'(rd), 32'(exp_rx[runq[q]]));
    end
    bus_read(7'h03, rd);
    check("R9 status after run", 32'(rd), 32'(16'h0080 | 16'(endp)));
    bus_write(7'h03, 16'h0080);
    bus_read(7'h03, rd);
    check("R9 finished cleared", 32'(rd), 32'(endp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; miso = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    #1;
    check("R1 cs", 32'(cs), 0);
    check("R1 sclk", 32'(sclk), 0);
    check("R1 mosi", 32'(mosi), 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(7'(a), rd);
      check("R1 control word", 32'(rd), 0);
    end

    // fill memories with distinct patterns
    for (int i = 0; i < 32; i++) begin
      txw[i]  = 16'(16'hA5C3 ^ (i * 16'h1357));
      slw[i]  = 16'(16'h3C5A ^ (i * 16'h0B6D));
      cmdw[i] = 8'(((i % 3) == 0 ? 8'h80 : 8'h00) | (8'(i % 15) + 8'h1));
      bus_write(7'h20 + 7'(i), txw[i]);
      bus_write(7'h60 + 7'(i), {8'hFF, cmdw[i]});
    end

    // R10: region decode and command byte read width
    bus_read(7'h20 + 7'd9, rd);
    check("R10 tx readback", 32'(rd), 32'(txw[9]));
    bus_read(7'h60 + 7'd9, rd);
    check("R10 cmd readback", 32'(rd), 32'(cmdw[9]));

    // R2: start ignored while disabled
    bus_write(7'h00, 16'h2002);
    bus_write(7'h01, 16'h8000);
    for (int k = 0; k < 3; k++) begin
      bus_read(7'h01, rd);
      check("R2 start ignored", 32'(rd[15]), 0);
      check("R2 cs stays idle", 32'(cs), 0);
    end

    // mode 0, 8 bits, keep bit on entry 0 and 3 (R8)
    run_queue(8, 1'b0, 1'b0, 2, 1, 0, 0, 3);
    // polarity 1, phase 1, 5 bits, divisor 0 acts as 1 (R4 R6)
    run_queue(5, 1'b1, 1'b1, 0, 0, 2, 4, 6);
    // full 16-bit word via length 0, phase 1 (R5)
    run_queue(0, 1'b0, 1'b1, 3, 3, 1, 7, 7);
    // polarity 1 phase 0, 12 bits, last entry has keep bit set (R9)
    run_queue(12, 1'b1, 1'b0, 2, 0, 0, 11, 12);
    // index wraps from 31 to 0 (R3)
    run_queue(3, 1'b0, 1'b0, 1, 2, 0, 30, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule